// File: doc/BRIEF.md
# Byte-Masked Quadword Store Unit

This unit carries out a masked 64-bit store. An operation presents a 64-bit data word, a 64-bit mask word, a base address and an address-width flag. The unit reduces the mask to eight byte enables, one from the top bit of each mask byte. If any enable is set, it issues one write request that carries the data, the enables and the address of every byte lane. The request is tagged non-temporal: it is write-combining, weakly ordered, write-only and never fetches or allocates the old line.

Each operation also updates the floating-point register-stack state. It pulses a write that sets the stack-top pointer to zero and the whole tag word to zero (every register valid). This happens even when no byte is enabled. An operation whose mask enables no byte finishes in one cycle without issuing a request. A `done` pulse marks the end of every operation.

Top module: `masked_qword_store`

## Requirements
- R1: Byte enable i (i = 0..7) on `mem_req_be[i]` equals `op_mask[8*i+7]`. The other 56 mask bits have no effect on any output.
- R2: `mem_req_data` equals `op_data` as captured at acceptance. Byte i of the data, bits [8*i+7:8*i], belongs to lane i.
- R3: The address of lane i, on `mem_req_lane_addr[32*i+31:32*i]`, is base+i. When `op_wide_addr`=0 the sum is taken modulo 2^16, the upper 16 base bits are ignored and the upper 16 address bits read 0. When `op_wide_addr`=1 the sum is taken modulo 2^32. `mem_req_addr` equals the lane 0 address.
- R4: While `mem_req_valid` is high, `mem_req_nt` is 1, marking a non-temporal, write-combining, write-only store that does not read or allocate the old line.
- R5: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address, lane addresses, data and enables do not change.
- R6: An operation with at least one enable raises `mem_req_valid` in the cycle after acceptance. `op_ready` stays low until the request retires (valid and ready both high at an edge). In the cycle after the retire, `done` is 1, `mem_req_valid` is 0 and `op_ready` is 1.
- R7: In the cycle after every acceptance, `fp_wr` is 1 for exactly that cycle, with `fp_top`=0 and `fp_tag`=0. This includes acceptances whose mask enables no byte.
- R8: An operation whose enables are all zero issues no request. In the cycle after acceptance `done` is 1 and `op_ready` stays 1. No request ever carries all-zero enables.
- R9: During and after reset, `mem_req_valid`, `done` and `fp_wr` are 0 and `op_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit can accept an operation |
| op_data | input | 64 | Source data word |
| op_mask | input | 64 | Mask word; top bit of each byte selects the lane |
| op_base | input | 32 | Base address |
| op_wide_addr | input | 1 | 1 = 32-bit addressing, 0 = 16-bit addressing |
| mem_req_valid | output | 1 | Write request valid |
| mem_req_ready | input | 1 | Memory side takes the request |
| mem_req_addr | output | 32 | Address of lane 0 |
| mem_req_lane_addr | output | 256 | Per-lane byte addresses, lane i at [32*i+31:32*i] |
| mem_req_data | output | 64 | Write data |
| mem_req_be | output | 8 | Byte enables |
| mem_req_nt | output | 1 | Non-temporal write-only attribute |
| done | output | 1 | One-cycle completion pulse |
| fp_wr | output | 1 | Floating-point state update strobe |
| fp_top | output | 3 | New stack-top pointer value |
| fp_tag | output | 16 | New tag word value |

## Verification
The bench sweeps all 256 enable patterns. The low seven bits of every mask byte carry changing junk, so a decoder that reads bit 0 instead of bit 7, or that ORs the byte, produces wrong enables. Base addresses sit next to the 16-bit and 32-bit wrap points, and in 16-bit mode the upper base bits are filled with junk. A design that does not truncate the sum, or that carries into bit 16, therefore shows wrong lane addresses. Back-pressure of zero to three cycles exposes a request that changes while it is stalled. The all-zero pattern catches a design that issues an empty write, skips the floating-point update or stalls for an extra cycle.

// File: rtl/mqs_pkg.sv
package mqs_pkg;
  localparam int LANES        = 8;
  localparam int BYTE_W       = 8;
  localparam int ADDR_W       = 32;
  localparam int SHORT_ADDR_W = 16;
  localparam int TOP_W        = 3;
  localparam int TAG_W        = 16;
  localparam int DATA_W       = LANES * BYTE_W;

  typedef enum logic [0:0] {ST_IDLE, ST_ISSUE} mqs_state_e;

  // Address of one byte lane: base + lane, wrapped to the active address width.
  function automatic logic [ADDR_W-1:0] lane_address(input logic [ADDR_W-1:0] base,
                                                      input int lane,
                                                      input logic wide);
    logic [ADDR_W-1:0] sum;
    sum = base + ADDR_W'(lane);
    if (!wide) sum[ADDR_W-1:SHORT_ADDR_W] = '0;
    return sum;
  endfunction
endpackage

// File: rtl/mqs_mask_decode.sv
module mqs_mask_decode #(
  parameter int LANES  = mqs_pkg::LANES,
  parameter int BYTE_W = mqs_pkg::BYTE_W,
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic [DATA_W-1:0] mask,
  output logic [LANES-1:0]  be,
  output logic              any_en
);
  // Only the top bit of each mask byte selects its lane.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be[g] = mask[g*BYTE_W + BYTE_W - 1];
  end
  assign any_en = |be;
endmodule

// File: rtl/mqs_lane_addr.sv
module mqs_lane_addr #(
  parameter int LANES  = mqs_pkg::LANES,
  parameter int ADDR_W = mqs_pkg::ADDR_W
) (
  input  logic [ADDR_W-1:0]       base,
  input  logic                    wide,
  output logic [LANES*ADDR_W-1:0] lanes
);
  for (genvar g = 0; g < LANES; g++) begin : g_addr
    assign lanes[g*ADDR_W +: ADDR_W] = mqs_pkg::lane_address(base, g, wide);
  end
endmodule

// File: rtl/mqs_req_ctrl.sv
module mqs_req_ctrl #(
  parameter int LANES  = mqs_pkg::LANES,
  parameter int BYTE_W = mqs_pkg::BYTE_W,
  parameter int ADDR_W = mqs_pkg::ADDR_W,
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic              any_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LANES-1:0]  in_be,
  input  logic [ADDR_W-1:0] in_base,
  input  logic              in_wide,
  input  logic              mem_ready,
  output logic              req_valid,
  output logic [DATA_W-1:0] req_data,
  output logic [LANES-1:0]  req_be,
  output logic [ADDR_W-1:0] req_base,
  output logic              req_wide,
  output logic              done,
  output logic              fp_wr
);
  import mqs_pkg::*;

  mqs_state_e state_q;
  logic accept_evt;
  logic retire_evt;

  assign op_ready   = (state_q == ST_IDLE);
  assign req_valid  = (state_q == ST_ISSUE);
  assign accept_evt = op_valid && op_ready;
  assign retire_evt = req_valid && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      done     <= 1'b0;
      fp_wr    <= 1'b0;
      req_data <= '0;
      req_be   <= '0;
      req_base <= '0;
      req_wide <= 1'b0;
    end else begin
      done  <= 1'b0;
      fp_wr <= accept_evt;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_evt) begin
            req_data <= in_data;
            req_be   <= in_be;
            req_base <= in_base;
            req_wide <= in_wide;
            if (any_en) state_q <= ST_ISSUE;
            else        done    <= 1'b1;
          end
        end
        ST_ISSUE: begin
          if (retire_evt) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !mem_ready |=> req_valid && $stable(req_data) && $stable(req_be)
                                && $stable(req_base) && $stable(req_wide));

  assert_retire_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retire_evt |=> done && !req_valid && op_ready);

  assert_issue_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt && any_en |=> req_valid && !op_ready && !done);

  assert_fp_every_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> fp_wr);

  assert_fp_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_evt |=> !fp_wr);

  assert_empty_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt && !any_en |=> done && !req_valid && op_ready);
endmodule

// File: rtl/masked_qword_store.sv
module masked_qword_store #(
  parameter int LANES  = mqs_pkg::LANES,
  parameter int BYTE_W = mqs_pkg::BYTE_W,
  parameter int ADDR_W = mqs_pkg::ADDR_W,
  parameter int TOP_W  = mqs_pkg::TOP_W,
  parameter int TAG_W  = mqs_pkg::TAG_W,
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_valid,
  output logic                    op_ready,
  input  logic [DATA_W-1:0]       op_data,
  input  logic [DATA_W-1:0]       op_mask,
  input  logic [ADDR_W-1:0]       op_base,
  input  logic                    op_wide_addr,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [ADDR_W-1:0]       mem_req_addr,
  output logic [LANES*ADDR_W-1:0] mem_req_lane_addr,
  output logic [DATA_W-1:0]       mem_req_data,
  output logic [LANES-1:0]        mem_req_be,
  output logic                    mem_req_nt,
  output logic                    done,
  output logic                    fp_wr,
  output logic [TOP_W-1:0]        fp_top,
  output logic [TAG_W-1:0]        fp_tag
);
  logic [LANES-1:0]  dec_be;
  logic              dec_any;
  logic [ADDR_W-1:0] req_base;
  logic              req_wide;

  mqs_mask_decode #(.LANES(LANES), .BYTE_W(BYTE_W)) u_decode (
    .mask   (op_mask),
    .be     (dec_be),
    .any_en (dec_any)
  );

  mqs_req_ctrl #(.LANES(LANES), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_ready  (op_ready),
    .any_en    (dec_any),
    .in_data   (op_data),
    .in_be     (dec_be),
    .in_base   (op_base),
    .in_wide   (op_wide_addr),
    .mem_ready (mem_req_ready),
    .req_valid (mem_req_valid),
    .req_data  (mem_req_data),
    .req_be    (mem_req_be),
    .req_base  (req_base),
    .req_wide  (req_wide),
    .done      (done),
    .fp_wr     (fp_wr)
  );

  mqs_lane_addr #(.LANES(LANES), .ADDR_W(ADDR_W)) u_lanes (
    .base  (req_base),
    .wide  (req_wide),
    .lanes (mem_req_lane_addr)
  );

  assign mem_req_addr = mem_req_lane_addr[ADDR_W-1:0];
  // Every request is a write-only, write-combining store.
  assign mem_req_nt   = 1'b1;
  // State transition: stack top to zero, all tags valid (zero).
  assign fp_top       = '0;
  assign fp_tag       = '0;

  assert_no_empty_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_be != '0);

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    assert_short_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !req_wide |->
        mem_req_lane_addr[g*ADDR_W + mqs_pkg::SHORT_ADDR_W +: ADDR_W - mqs_pkg::SHORT_ADDR_W] == '0);
  end
endmodule

// File: tb/masked_qword_store_tb.sv
`timescale 1ns/1ps
module masked_qword_store_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         op_valid;
  logic         op_ready;
  logic [63:0]  op_data;
  logic [63:0]  op_mask;
  logic [31:0]  op_base;
  logic         op_wide_addr;
  logic         mem_req_valid;
  logic         mem_req_ready;
  logic [31:0]  mem_req_addr;
  logic [255:0] mem_req_lane_addr;
  logic [63:0]  mem_req_data;
  logic [7:0]   mem_req_be;
  logic         mem_req_nt;
  logic         done;
  logic         fp_wr;
  logic [2:0]   fp_top;
  logic [15:0]  fp_tag;

  int checks = 0;
  int errors = 0;
  logic [63:0] seed = 64'h1234_5678_9abc_def1;

  always #4 clk = ~clk;

  masked_qword_store dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_data(op_data), .op_mask(op_mask), .op_base(op_base), .op_wide_addr(op_wide_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_lane_addr(mem_req_lane_addr), .mem_req_data(mem_req_data), .mem_req_be(mem_req_be),
    .mem_req_nt(mem_req_nt), .done(done), .fp_wr(fp_wr), .fp_top(fp_top), .fp_tag(fp_tag)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] next_rand();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed;
  endfunction

  task automatic check_request(input logic [63:0] d, input logic [7:0] be,
                               input logic [31:0] base, input logic wide);
    logic [255:0] exp_lanes;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a;
      a = base + 32'(i);
      if (!wide) a = {16'h0, a[15:0]};
      exp_lanes[32*i +: 32] = a;
    end
    chk(mem_req_valid === 1'b1, "R6 valid", 256'(mem_req_valid), 256'd1);
    chk(mem_req_be === be, "R1 enables", 256'(mem_req_be), 256'(be));
    chk(mem_req_data === d, "R2 data", 256'(mem_req_data), 256'(d));
    chk(mem_req_lane_addr === exp_lanes, "R3 lanes", mem_req_lane_addr, exp_lanes);
    chk(mem_req_addr === exp_lanes[31:0], "R3 addr", 256'(mem_req_addr), 256'(exp_lanes[31:0]));
    chk(mem_req_nt === 1'b1, "R4 nt", 256'(mem_req_nt), 256'd1);
    chk(op_ready === 1'b0, "R6 busy", 256'(op_ready), 256'd0);
  endtask

  task automatic do_op(input logic [63:0] d, input logic [63:0] m,
                       input logic [31:0] base, input logic wide, input int stall);
    logic [7:0] be;
    for (int i = 0; i < 8; i++) be[i] = m[8*i+7];
    chk(op_ready === 1'b1, "R6 ready before", 256'(op_ready), 256'd1);
    op_valid = 1'b1; op_data = d; op_mask = m; op_base = base; op_wide_addr = wide;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0;
    op_data = next_rand(); op_mask = next_rand(); op_base = 32'(next_rand());
    chk(fp_wr === 1'b1 && fp_top === 3'd0 && fp_tag === 16'd0, "R7 fp update",
        {fp_wr, fp_top, fp_tag}, {1'b1, 3'd0, 16'd0});
    if (be == 8'h00) begin
      chk(mem_req_valid === 1'b0, "R8 no request", 256'(mem_req_valid), 256'd0);
      chk(done === 1'b1, "R8 done", 256'(done), 256'd1);
      chk(op_ready === 1'b1, "R8 ready", 256'(op_ready), 256'd1);
    end else begin
      chk(done === 1'b0, "R6 no early done", 256'(done), 256'd0);
      check_request(d, be, base, wide);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(fp_wr === 1'b0, "R7 single pulse", 256'(fp_wr), 256'd0);
        check_request(d, be, base, wide); // R5 hold under stall
      end
      mem_req_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      mem_req_ready = 1'b0;
      chk(done === 1'b1 && mem_req_valid === 1'b0 && op_ready === 1'b1, "R6 retire",
          {done, mem_req_valid, op_ready}, {1'b1, 1'b0, 1'b1});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_data = '0; op_mask = '0; op_base = '0;
    op_wide_addr = 1'b0; mem_req_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_req_valid === 0 && done === 0 && fp_wr === 0 && op_ready === 1, "R9 reset",
        {mem_req_valid, done, fp_wr, op_ready}, 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req_valid === 0 && done === 0 && fp_wr === 0 && op_ready === 1, "R9 after reset",
        {mem_req_valid, done, fp_wr, op_ready}, 4'b0001);
    for (int p = 0; p < 256; p++) begin
      logic [63:0] m, d;
      logic [31:0] base;
      logic wide;
      m = next_rand() & 64'h7f7f_7f7f_7f7f_7f7f;
      for (int i = 0; i < 8; i++) m[8*i+7] = p[i];
      d = next_rand();
      wide = p[0] ^ p[4];
      case (p % 4)
        0: base = 32'hABCD_FFFC;
        1: base = 32'hFFFF_FFFA;
        2: base = 32'h0000_FFFE;
        default: base = 32'(next_rand());
      endcase
      do_op(d, m, base, wide, p % 4);
    end
    // Empty mask with every low bit set: nothing may be issued (R1, R8).
    do_op(64'hDEAD_BEEF_0123_4567, 64'h7f7f_7f7f_7f7f_7f7f, 32'h1234_5678, 1'b1, 0);
    @(negedge clk);
    chk(mem_req_valid === 1'b0 && done === 1'b0, "R8 idle after empty",
        {mem_req_valid, done}, 2'b00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule